// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction RISC Core

This block is a small processor that completes every instruction in a single clock cycle. On each edge it fetches the word at the program counter and decodes it. It reads two registers, runs the ALU and accesses data memory. It then commits the register or memory result and loads the next program counter, all on that same edge.

The core recognises seven operations: add, sub, ori, lw, sw, beq and j. Both memories live inside the block. Each memory has a plain side port, so a testbench or loader can fill program and data while the core is held in reset, and can inspect data memory and the register file afterwards. Register file and memory reads are combinational; only writes use the clock.

The current program counter and instruction are brought out for observation. The block has no streaming data interface, so all pins are plain control and status signals with no handshake.

Top module: `mini_risc_core`

## Requirements
- R1: While rst_n is low (asynchronous, active low), pc_o is 0 and every register reads 0; after release the first instruction executed is the word at instruction-memory index 0.
- R2: Each rising clock edge out of reset retires exactly one instruction; for any non-control-flow instruction the next pc_o equals pc_o + 4, and instr_o always shows the memory word at index pc_o[IMEM_AW+1:2].
- R3: Opcode bits [31:26] = 0x00 with funct bits [5:0] = 0x20 writes R[rs] + R[rt] into R[rd], and funct 0x22 writes R[rs] - R[rt] into R[rd]. Here rs = [25:21], rt = [20:16] and rd = [15:11].
- R4: Opcode 0x0D writes R[rs] OR the zero-extended imm16 (bits [15:0]) into R[rt].
- R5: Opcode 0x23 loads into R[rt] the data word at byte address R[rs] + sign-extended imm16. Opcode 0x2B stores R[rt] to that address. The data-memory word index is address bits [DMEM_AW+1:2].
- R6: Opcode 0x04 compares R[rs] with R[rt]. When they are equal, the next PC is pc + 4 + 4*sign-extended imm16, so backward offsets are honoured. Otherwise the next PC is pc + 4.
- R7: Opcode 0x02 sets the next PC to {(pc+4)[31:28], target[25:0], 2'b00}.
- R8: Register 0 always reads as zero; any write aimed at it leaves it zero.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes no register and no memory, and the PC advances by 4.
- R10: prog_we writes prog_wdata into instruction-memory word prog_addr on the clock edge. dbg_dmem_we does the same for data-memory word dbg_dmem_addr, though a core store on the same edge takes priority. dbg_dmem_rdata and dbg_reg_val are combinational reads of the selected data word and register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of PC and registers |
| prog_we | input | 1 | Instruction-memory write strobe |
| prog_addr | input | IMEM_AW | Instruction-memory word index |
| prog_wdata | input | 32 | Instruction word to write |
| dbg_dmem_we | input | 1 | Data-memory side-port write strobe |
| dbg_dmem_addr | input | DMEM_AW | Data-memory side-port word index |
| dbg_dmem_wdata | input | 32 | Data word to write through the side port |
| dbg_dmem_rdata | output | 32 | Data word at dbg_dmem_addr (combinational) |
| dbg_reg_sel | input | 5 | Register index to observe |
| dbg_reg_val | output | 32 | Value of register dbg_reg_sel (combinational) |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction at the current program counter |

## Verification
An instruction's register write, memory write and next PC all appear right after the rising edge that executes it. Once reset is released, the k-th edge has retired exactly the first k instructions on the program's path. Each scenario releases reset at a falling edge, counts the required rising edges, and samples pc_o at the next falling edge. Every program ends in a jump to itself, so the register and data-memory values stay stable while the side ports are read one by one after the run.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    imm_zext;
    alu_op_e alu_op;
    logic    mem_wr;
    logic    load_sel;
    logic    is_branch;
    logic    is_jump;
  } ctrl_t;
endpackage

// File: rtl/rc_decoder.sv
module rc_decoder
  import rc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctl.reg_wr    = 1'b1;
          ctl.dst_is_rd = 1'b1;
          ctl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctl.reg_wr   = 1'b1;
        ctl.b_is_imm = 1'b1;
        ctl.imm_zext = 1'b1;
        ctl.alu_op   = ALU_OR;
      end
      OP_LOAD: begin
        ctl.reg_wr   = 1'b1;
        ctl.b_is_imm = 1'b1;
        ctl.load_sel = 1'b1;
      end
      OP_STORE: begin
        ctl.b_is_imm = 1'b1;
        ctl.mem_wr   = 1'b1;
      end
      OP_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.alu_op    = ALU_SUB;
      end
      OP_JUMP: ctl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int DW    = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] rd_dbg,
  output logic [DW-1:0] bus_a,
  output logic [DW-1:0] bus_b,
  output logic [DW-1:0] bus_dbg,
  input  logic          we,
  input  logic [AW-1:0] rw,
  input  logic [DW-1:0] bus_w
);
  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && rw != '0) begin
      regs[rw] <= bus_w;
    end
  end

  assign bus_a   = (ra == '0)     ? '0 : regs[ra];
  assign bus_b   = (rb == '0)     ? '0 : regs[rb];
  assign bus_dbg = (rd_dbg == '0) ? '0 : regs[rd_dbg];
endmodule

// File: rtl/rc_fetch.sv
module rc_fetch #(
  parameter int IMEM_WORDS = 64,
  localparam int IA = $clog2(IMEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [IA-1:0] prog_addr,
  input  logic [31:0]   prog_wdata,
  input  logic          take_branch,
  input  logic          take_jump,
  output logic [31:0]   pc,
  output logic [31:0]   instr
);
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] pc_seq, pc_br, pc_jmp, pc_next;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_wdata;
  end

  assign instr   = imem[pc[IA+1:2]];
  assign pc_seq  = pc + 32'd4;
  assign pc_br   = pc_seq + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign pc_jmp  = {pc_seq[31:28], instr[25:0], 2'b00};
  assign pc_next = take_jump ? pc_jmp : (take_branch ? pc_br : pc_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end
endmodule

// File: rtl/mini_risc_core.sv
module mini_risc_core
  import rc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IMEM_AW   = $clog2(IMEM_WORDS),
  localparam int DMEM_AW   = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [31:0]        prog_wdata,
  input  logic               dbg_dmem_we,
  input  logic [DMEM_AW-1:0] dbg_dmem_addr,
  input  logic [31:0]        dbg_dmem_wdata,
  output logic [31:0]        dbg_dmem_rdata,
  input  logic [4:0]         dbg_reg_sel,
  output logic [31:0]        dbg_reg_val,
  output logic [31:0]        pc_o,
  output logic [31:0]        instr_o
);
  ctrl_t       ctl;
  logic [31:0] instr, bus_a, bus_b, bus_w, ext_imm, alu_b, alu_y, load_word;
  logic        alu_zero;
  logic [4:0]  dst;
  logic [DMEM_AW-1:0] d_idx;
  logic [31:0] dmem [DMEM_WORDS];

  rc_fetch #(.IMEM_WORDS(IMEM_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .take_branch(ctl.is_branch & alu_zero), .take_jump(ctl.is_jump),
    .pc(pc_o), .instr(instr)
  );

  rc_decoder u_dec (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign dst = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

  rc_regfile #(.DW(32), .NREGS(32)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra(instr[25:21]), .rb(instr[20:16]), .rd_dbg(dbg_reg_sel),
    .bus_a(bus_a), .bus_b(bus_b), .bus_dbg(dbg_reg_val),
    .we(ctl.reg_wr), .rw(dst), .bus_w(bus_w)
  );

  assign ext_imm = ctl.imm_zext ? {16'h0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctl.b_is_imm ? ext_imm : bus_b;

  rc_alu #(.DW(32)) u_alu (.a(bus_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero));

  assign d_idx     = alu_y[DMEM_AW+1:2];
  assign load_word = dmem[d_idx];
  assign bus_w     = ctl.load_sel ? load_word : alu_y;

  always_ff @(posedge clk) begin
    if (rst_n && ctl.mem_wr)  dmem[d_idx] <= bus_b;
    else if (dbg_dmem_we)     dmem[dbg_dmem_addr] <= dbg_dmem_wdata;
  end

  assign dbg_dmem_rdata = dmem[dbg_dmem_addr];
  assign instr_o        = instr;
endmodule

// File: rtl/rc_checker.sv
module rc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [4:0]  dbg_sel,
  input logic [31:0] dbg_val
);
  logic [31:0] pc4;
  logic        op_known;
  assign pc4 = pc + 32'd4;
  assign op_known = (instr[31:26] == 6'h00) || (instr[31:26] == 6'h0D) ||
                    (instr[31:26] == 6'h23) || (instr[31:26] == 6'h2B) ||
                    (instr[31:26] == 6'h04) || (instr[31:26] == 6'h02);

  // R1
  reset_pc_zero_chk: assert property (@(posedge clk) !rst_n |-> pc == 32'd0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'h0D) |=> pc == $past(pc) + 32'd4);

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'h02) |=> pc == {$past(pc4[31:28]), $past(instr[25:0]), 2'b00});

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel == 5'd0) |-> dbg_val == 32'd0);

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known |=> pc == $past(pc) + 32'd4);
endmodule

bind mini_risc_core rc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc_o), .instr(instr_o),
  .dbg_sel(dbg_reg_sel), .dbg_val(dbg_reg_val)
);

// File: tb/mini_risc_core_bench.sv
`timescale 1ns/1ps
module mini_risc_core_bench;
  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_wdata = '0;
  logic        dbg_dmem_we = 1'b0;
  logic [5:0]  dbg_dmem_addr = '0;
  logic [31:0] dbg_dmem_wdata = '0;
  logic [31:0] dbg_dmem_rdata;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val;
  logic [31:0] pc_o, instr_o;

  int total = 0;
  int bad = 0;
  logic [31:0] prog [16];
  int plen;

  mini_risc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_mini_risc_core (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .dbg_dmem_we(dbg_dmem_we), .dbg_dmem_addr(dbg_dmem_addr),
    .dbg_dmem_wdata(dbg_dmem_wdata), .dbg_dmem_rdata(dbg_dmem_rdata),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .pc_o(pc_o), .instr_o(instr_o)
  );

  always #2.5 clk = ~clk;

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reg(string req, int r, logic [31:0] exp);
    dbg_reg_sel = 5'(r);
    #0.5;
    check(req, dbg_reg_val, exp);
  endtask

  task automatic check_dmem(string req, int a, logic [31:0] exp);
    dbg_dmem_addr = 6'(a);
    #0.5;
    check(req, dbg_dmem_rdata, exp);
  endtask

  // hold reset, load program (rest zero-filled, an unrecognised funct)
  task automatic load_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      prog_we = 1'b1;
      prog_addr = 6'(i);
      prog_wdata = (i < plen) ? prog[i] : 32'h0;
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run(int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_arith();
    prog[0] = enc_i(6'h0D, 0, 1, 16'h00F0);
    prog[1] = enc_i(6'h0D, 0, 2, 16'h000F);
    prog[2] = enc_r(1, 2, 3, 6'h20);
    prog[3] = enc_r(1, 2, 4, 6'h22);
    prog[4] = enc_r(2, 1, 12, 6'h22);
    prog[5] = enc_j(5);
    plen = 6;
    load_prog();
    run(5);
    check("R2 pc after 5 cycles", pc_o, 32'd20);
    check_reg("R3 add", 3, 32'h0000_00FF);
    check_reg("R3 sub", 4, 32'h0000_00E1);
    check_reg("R3 sub negative", 12, 32'hFFFF_FF1F);
  endtask

  task automatic t_reset();
    prog[0] = enc_i(6'h0D, 0, 7, 16'h1111);
    prog[1] = enc_j(1);
    plen = 2;
    load_prog();
    check("R1 pc in reset", pc_o, 32'd0);
    check("R1 instr at index 0", instr_o, prog[0]);
    check_reg("R1 reg cleared", 3, 32'd0);
    run(1);
    check_reg("R1 first instr executed", 7, 32'h1111);
    check("R2 instr_o follows pc", instr_o, prog[1]);
  endtask

  task automatic t_imm_r0();
    prog[0] = enc_i(6'h0D, 0, 8, 16'hFFFF);
    prog[1] = enc_i(6'h0D, 0, 0, 16'h0005);
    prog[2] = enc_r(8, 8, 0, 6'h20);
    prog[3] = enc_j(3);
    plen = 4;
    load_prog();
    run(3);
    check("R2 pc", pc_o, 32'd12);
    check_reg("R4 ori zero-extend", 8, 32'h0000_FFFF);
    check_reg("R8 r0 stays zero", 0, 32'd0);
  endtask

  task automatic t_mem();
    prog[0] = enc_i(6'h0D, 0, 1, 16'h1234);
    prog[1] = enc_i(6'h0D, 0, 6, 16'h0010);
    prog[2] = enc_i(6'h2B, 0, 1, 16'h0008);
    prog[3] = enc_i(6'h23, 0, 5, 16'h0008);
    prog[4] = enc_i(6'h23, 6, 7, 16'hFFF8);
    prog[5] = enc_i(6'h2B, 6, 6, 16'hFFFC);
    prog[6] = enc_j(6);
    plen = 7;
    load_prog();
    run(6);
    check("R2 pc", pc_o, 32'd24);
    check_dmem("R5 store", 2, 32'h1234);
    check_dmem("R5 store negative offset", 3, 32'h10);
    check_reg("R5 load", 5, 32'h1234);
    check_reg("R5 load negative offset", 7, 32'h1234);
  endtask

  task automatic t_branch();
    prog[0] = enc_i(6'h0D, 0, 1, 16'h0005);
    prog[1] = enc_i(6'h0D, 0, 2, 16'h0005);
    prog[2] = enc_i(6'h04, 1, 2, 16'h0002);
    prog[3] = enc_i(6'h0D, 0, 9, 16'h0001);
    prog[4] = enc_i(6'h0D, 0, 9, 16'h0002);
    prog[5] = enc_i(6'h0D, 0, 10, 16'h0007);
    prog[6] = enc_i(6'h04, 1, 0, 16'h0005);
    prog[7] = enc_i(6'h0D, 0, 11, 16'h0003);
    prog[8] = enc_i(6'h04, 0, 0, 16'hFFFE);
    plen = 9;
    load_prog();
    run(6);
    check("R6 taken then not taken pc", pc_o, 32'd32);
    @(negedge clk);
    check("R6 backward branch pc", pc_o, 32'd28);
    check_reg("R6 skipped r9", 9, 32'd0);
    check_reg("R6 target r10", 10, 32'd7);
    check_reg("R6 fallthrough r11", 11, 32'd3);
  endtask

  task automatic t_jump();
    prog[0] = enc_j(4);
    prog[1] = enc_i(6'h0D, 0, 9, 16'h0001);
    prog[2] = enc_i(6'h0D, 0, 9, 16'h0001);
    prog[3] = enc_i(6'h0D, 0, 9, 16'h0001);
    prog[4] = enc_i(6'h0D, 0, 10, 16'h0009);
    prog[5] = enc_j(5);
    plen = 6;
    load_prog();
    run(1);
    check("R7 jump target", pc_o, 32'd16);
    @(negedge clk);
    @(negedge clk);
    check("R7 jump to self", pc_o, 32'd20);
    check_reg("R7 skipped r9", 9, 32'd0);
    check_reg("R7 target r10", 10, 32'd9);
  endtask

  task automatic t_illegal();
    prog[0] = enc_i(6'h0D, 0, 1, 16'h0077);
    prog[1] = enc_i(6'h3F, 1, 2, 16'h0001);
    prog[2] = enc_r(1, 1, 3, 6'h25);
    prog[3] = enc_i(6'h2A, 0, 1, 16'h0000);
    prog[4] = enc_j(4);
    plen = 5;
    load_prog();
    @(negedge clk);
    dbg_dmem_we = 1'b1; dbg_dmem_addr = 6'd0; dbg_dmem_wdata = 32'hA5A5;
    @(negedge clk);
    dbg_dmem_we = 1'b0;
    check_dmem("R10 side-port write", 0, 32'hA5A5);
    run(4);
    check("R9 pc advanced sequentially", pc_o, 32'd16);
    check_reg("R9 unknown opcode no write", 2, 32'd0);
    check_reg("R9 unknown funct no write", 3, 32'd0);
    check_dmem("R9 unknown opcode no store", 0, 32'hA5A5);
    check_reg("R4 ori ok before", 1, 32'h77);
  endtask

  initial begin
    t_arith();
    t_reset();
    t_imm_r0();
    t_mem();
    t_branch();
    t_jump();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule